// File: doc/BRIEF.md
# Configuration Header with Region Decode

This block holds the 256-byte configuration space of one type-0 function and turns its base address registers into ready-to-use address windows. A host-side agent reads and writes the space through a simple access port that carries a byte offset, a length of 1, 2 or 4 bytes, and little-endian data. Every byte has a fixed write mask. Identity bytes therefore keep their built-in values. Only the defined control bits of the command word accept new values. The vendor-specific area from offset 0x40 up is plain storage.

Six base address registers and one expansion ROM register are decoded into seven region outputs. Each output is a valid flag plus the size-aligned base address. Sizes, I/O versus memory type, and which registers exist at all are set by parameters. The region outputs are registered. They are refreshed only when a write actually changes a base address register byte or one of the two space enables. A downstream address decoder compares bus addresses against these outputs. This block forwards no transactions itself.

Top module: `cfg_header_bar`

## Requirements
- R1: After reset, offsets 0x00-0x03 read the vendor and device identifiers and offsets 0x08-0x0B read the revision and class code. The command word reads 0. An implemented I/O register reads 0x00000001 and every other region register reads 0. All seven regions are unmapped.
- R2: A write replaces each byte as (old & ~mask) | (data & mask). The mask is 0x07 for offset 0x04 (bit 0 I/O enable, bit 1 memory enable, bit 2 bus master) and 0 for offset 0x05. It is 0xFF for offsets 0x0C and 0x3C and for all of 0x40-0xFF. Identity bytes have mask 0 and never change.
- R3: Length 1, 2 or 4 selects that many bytes starting at the offset. The byte at the offset sits in data bits 7:0. Read data and its valid flag appear one clock after the request. Write bytes that would land beyond offset 0xFF are discarded, and read bytes beyond 0xFF return 0.
- R4: Region register n sits at offset 0x10+4n, and the ROM register sits at 0x30 (0x38 for a bridge header). The low log2(size) bits of an implemented register are read-only and hold the type value (bit 0 = 1 for I/O). Bit 0 of the ROM register, its enable, stays writable.
- R5: A region register whose size parameter is 0 always reads 0. Writes to it have no effect, and its region is never mapped.
- R6: An I/O region is mapped only if command bit 0 is set, its aligned base is non-zero, and its last address is below 0x10000.
- R7: A memory region is mapped only if command bit 1 is set, its aligned base is non-zero, and its last address neither wraps nor equals 0xFFFFFFFF.
- R8: The ROM region additionally needs bit 0 of its own register set.
- R9: Region outputs update on the second clock edge after a write. They update only when that write changed a byte in 0x10-0x27 or bit 0 or bit 1 of offset 0x04. A ROM register write alone leaves the region outputs unchanged.
- R10: The base output of an unmapped region is 0.
- R11: A reset after use restores the command word, offsets 0x0C and 0x3C, and every region register to the R1 values, and unmaps all regions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgValid | input | 1 | Access request this cycle |
| cfgWrite | input | 1 | 1 = write, 0 = read |
| cfgOffset | input | 8 | Starting byte offset |
| cfgLen | input | 3 | Byte count: 1, 2 or 4 |
| cfgWdata | input | 32 | Write data, little-endian |
| cfgRdata | output | 32 | Read data, little-endian |
| cfgRdValid | output | 1 | Read data valid |
| regionValid | output | 7 | Per-region mapped flag; bit 6 is the ROM |
| regionBase | output | 224 | Per-region base, region r in bits 32r+31:32r |

## Verification
Read data is due one clock after the request edge. The scoreboard queues each expected word when the read is driven, and the monitor pops it on the falling edge that follows the next rising edge. Region outputs are due one edge after the write edge, so each region check waits one further falling edge after the write completes before it samples. The ROM case checks that a write to the ROM register alone leaves the region outputs unchanged, and that a later write to a base address register byte does refresh them.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int CFG_BYTES   = 256;
  localparam int NUM_BARS    = 6;
  localparam int NUM_REGIONS = NUM_BARS + 1;
  localparam int ROM_IDX     = NUM_BARS;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic remap;
  } cfgStrobes_t;
endpackage

// File: rtl/cfg_hdr_ctrl.sv
module cfg_hdr_ctrl
  import cfg_hdr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cfgValid,
  input  logic        cfgWrite,
  input  logic        changeHit,
  output cfgStrobes_t st,
  output logic        rdValid
);
  logic remapQ;

  always_comb begin
    st.wrEn  = cfgValid & cfgWrite;
    st.rdEn  = cfgValid & ~cfgWrite;
    st.remap = remapQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remapQ  <= 1'b0;
      rdValid <= 1'b0;
    end else begin
      remapQ  <= cfgValid & cfgWrite & changeHit;  // R9 trigger
      rdValid <= cfgValid & ~cfgWrite;             // R3 latency
    end
  end
endmodule

// File: rtl/cfg_hdr_datapath.sv
module cfg_hdr_datapath
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID  = 16'h5A17,
  parameter logic [23:0] CLASS_CODE = 24'h0B4000,
  parameter logic [7:0]  REVISION   = 8'h03,
  parameter bit          HDR_BRIDGE = 1'b0,
  parameter logic [6*NUM_BARS-1:0] BAR_LOG2 = {6'd0, 6'd0, 6'd20, 6'd0, 6'd12, 6'd4},
  parameter logic [NUM_BARS-1:0]   BAR_IO   = 6'b000001,
  parameter logic [5:0]  ROM_LOG2   = 6'd11
)(
  input  logic        clk,
  input  logic        rst,
  input  cfgStrobes_t st,
  input  logic [7:0]  offset,
  input  logic [2:0]  len,
  input  logic [31:0] wdata,
  output logic        changeHit,
  output logic [31:0] rdata,
  output logic [NUM_REGIONS-1:0]    regionValid,
  output logic [NUM_REGIONS*32-1:0] regionBase
);
  localparam logic [7:0] ROM_OFF  = HDR_BRIDGE ? 8'h38 : 8'h30;
  localparam logic [7:0] HDR_TYPE = HDR_BRIDGE ? 8'h01 : 8'h00;

  function automatic logic [5:0] regionLog2(int r);
    if (r == ROM_IDX) return ROM_LOG2;
    return BAR_LOG2[6*r +: 6];
  endfunction

  function automatic logic [7:0] regionOff(int r);
    if (r == ROM_IDX) return ROM_OFF;
    return 8'(16 + 4*r);
  endfunction

  function automatic bit regionIsIo(int r);
    if (r == ROM_IDX) return 1'b0;
    return BAR_IO[r];
  endfunction

  function automatic logic [31:0] regionMask(int r);
    logic [5:0]  l;
    logic [31:0] m;
    l = regionLog2(r);
    if (l == 6'd0) return 32'h0;
    m = ~((32'd1 << l) - 32'd1);
    if (r == ROM_IDX) m[0] = 1'b1;
    return m;
  endfunction

  function automatic logic [7:0] wmaskOf(logic [7:0] a);
    logic [7:0]  o;
    logic [31:0] m;
    if (a >= 8'h40) return 8'hFF;
    if (a == 8'h04) return 8'h07;
    if (a == 8'h0C || a == 8'h3C) return 8'hFF;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      o = regionOff(r);
      if (a[7:2] == o[7:2]) begin
        m = regionMask(r);
        return m[8*a[1:0] +: 8];
      end
    end
    return 8'h00;
  endfunction

  function automatic logic [7:0] initOf(logic [7:0] a);
    case (a)
      8'h00: return VENDOR_ID[7:0];
      8'h01: return VENDOR_ID[15:8];
      8'h02: return DEVICE_ID[7:0];
      8'h03: return DEVICE_ID[15:8];
      8'h08: return REVISION;
      8'h09: return CLASS_CODE[7:0];
      8'h0A: return CLASS_CODE[15:8];
      8'h0B: return CLASS_CODE[23:16];
      8'h0E: return HDR_TYPE;
      default: ;
    endcase
    for (int r = 0; r < NUM_BARS; r++)
      if (a == regionOff(r) && regionIsIo(r) && regionLog2(r) != 6'd0) return 8'h01;
    return 8'h00;
  endfunction

  logic [7:0] cfgMem [CFG_BYTES];
  logic [3:0] lane;
  logic [7:0] laneIdx  [4];
  logic [7:0] laneByte [4];
  logic [31:0] rdNext;

  always_comb begin
    changeHit = 1'b0;
    rdNext    = 32'h0;
    for (int k = 0; k < 4; k++) begin
      logic [8:0] idx9;
      logic [7:0] wm, old;
      idx9        = {1'b0, offset} + 9'(k);
      lane[k]     = (3'(k) < len) && !idx9[8];
      laneIdx[k]  = idx9[7:0];
      old         = cfgMem[idx9[7:0]];
      wm          = wmaskOf(idx9[7:0]);
      laneByte[k] = (old & ~wm) | (wdata[8*k +: 8] & wm);
      if (lane[k]) begin
        rdNext[8*k +: 8] = old;
        if (idx9[7:0] >= 8'h10 && idx9[7:0] < 8'h28 && laneByte[k] != old) changeHit = 1'b1;
        if (idx9[7:0] == 8'h04 && (laneByte[k][1:0] != old[1:0])) changeHit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CFG_BYTES; i++) cfgMem[i] <= initOf(8'(i));
    end else if (st.wrEn) begin
      for (int k = 0; k < 4; k++)
        if (lane[k]) cfgMem[laneIdx[k]] <= laneByte[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= 32'h0;
    else if (st.rdEn) rdata <= rdNext;
  end

  logic ioEn, memEn;
  logic [NUM_REGIONS-1:0] hitVec;
  logic [31:0] baseArr [NUM_REGIONS];
  assign ioEn  = cfgMem[4][0];
  assign memEn = cfgMem[4][1];

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    localparam logic [5:0]  L     = regionLog2(r);
    localparam logic [7:0]  OFF   = regionOff(r);
    localparam bit          IS_IO = regionIsIo(r);
    localparam bit          IS_ROM = (r == ROM_IDX);
    localparam logic [32:0] SIZE  = 33'd1 << L;
    logic [31:0] raw, base;
    logic [32:0] last;
    assign raw  = {cfgMem[OFF+8'd3], cfgMem[OFF+8'd2], cfgMem[OFF+8'd1], cfgMem[OFF]};
    assign base = raw & ~(SIZE[31:0] - 32'd1);
    assign last = {1'b0, base} + SIZE - 33'd1;
    if (L == 6'd0) begin : g_absent
      assign hitVec[r] = 1'b0;
    end else if (IS_IO) begin : g_io
      assign hitVec[r] = ioEn && base != 32'h0 && last < 33'h10000;
    end else begin : g_mem
      assign hitVec[r] = memEn && base != 32'h0 && !last[32] && last[31:0] != 32'hFFFF_FFFF
                         && (!IS_ROM || raw[0]);
    end
    assign baseArr[r] = hitVec[r] ? base : 32'h0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regionValid <= '0;
      regionBase  <= '0;
    end else if (st.remap) begin
      regionValid <= hitVec;
      for (int r = 0; r < NUM_REGIONS; r++) regionBase[32*r +: 32] <= baseArr[r];
    end
  end
endmodule

// File: rtl/cfg_header_bar.sv
module cfg_header_bar
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID  = 16'h5A17,
  parameter logic [23:0] CLASS_CODE = 24'h0B4000,
  parameter logic [7:0]  REVISION   = 8'h03,
  parameter bit          HDR_BRIDGE = 1'b0,
  parameter logic [6*NUM_BARS-1:0] BAR_LOG2 = {6'd0, 6'd0, 6'd20, 6'd0, 6'd12, 6'd4},
  parameter logic [NUM_BARS-1:0]   BAR_IO   = 6'b000001,
  parameter logic [5:0]  ROM_LOG2   = 6'd11
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        cfgValid,
  input  logic        cfgWrite,
  input  logic [7:0]  cfgOffset,
  input  logic [2:0]  cfgLen,
  input  logic [31:0] cfgWdata,
  output logic [31:0] cfgRdata,
  output logic        cfgRdValid,
  output logic [6:0]  regionValid,
  output logic [223:0] regionBase
);
  cfgStrobes_t st;
  logic changeHit;

  cfg_hdr_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cfgValid(cfgValid), .cfgWrite(cfgWrite),
    .changeHit(changeHit), .st(st), .rdValid(cfgRdValid)
  );

  cfg_hdr_datapath #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .CLASS_CODE(CLASS_CODE),
    .REVISION(REVISION), .HDR_BRIDGE(HDR_BRIDGE), .BAR_LOG2(BAR_LOG2),
    .BAR_IO(BAR_IO), .ROM_LOG2(ROM_LOG2)
  ) u_dp (
    .clk(clk), .rst(rst), .st(st), .offset(cfgOffset), .len(cfgLen),
    .wdata(cfgWdata), .changeHit(changeHit), .rdata(cfgRdata),
    .regionValid(regionValid), .regionBase(regionBase)
  );
endmodule

// File: rtl/cfg_header_bar_checker.sv
module cfg_header_bar_checker #(
  parameter logic [35:0] BAR_LOG2 = 36'h0,
  parameter logic [5:0]  BAR_IO   = 6'h0
)(
  input logic         clk,
  input logic         rst,
  input logic         cfgValid,
  input logic         cfgWrite,
  input logic         cfgRdValid,
  input logic [6:0]   regionValid,
  input logic [223:0] regionBase
);
  // R3: read data valid exactly one cycle after a read request
  assert_rd_latency_R3: assert property (@(posedge clk) disable iff (rst)
    cfgRdValid == $past(cfgValid && !cfgWrite));

  // R9: with no write two edges back, region outputs hold
  assert_hold_without_write_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(cfgValid && cfgWrite, 2) |-> ($stable(regionValid) && $stable(regionBase)));

  for (genvar r = 0; r < 7; r++) begin : g_chk
    // R10: unmapped region shows zero base
    assert_base_zero_R10: assert property (@(posedge clk) disable iff (rst)
      !regionValid[r] |-> regionBase[32*r +: 32] == 32'h0);
    // R7: a mapped region never sits at base zero
    assert_nonzero_base_R7: assert property (@(posedge clk) disable iff (rst)
      regionValid[r] |-> regionBase[32*r +: 32] != 32'h0);
    if (r < 6) begin : g_bar
      if (BAR_LOG2[6*r +: 6] == 6'd0) begin : g_absent
        // R5: unimplemented register never maps
        assert_absent_unmapped_R5: assert property (@(posedge clk) disable iff (rst)
          !regionValid[r]);
      end else if (BAR_IO[r]) begin : g_io
        // R6: mapped I/O window ends below 0x10000
        assert_io_below_64k_R6: assert property (@(posedge clk) disable iff (rst)
          regionValid[r] |-> ({1'b0, regionBase[32*r +: 32]}
                               + (33'd1 << BAR_LOG2[6*r +: 6]) - 33'd1) < 33'h10000);
      end
    end
  end
endmodule

bind cfg_header_bar cfg_header_bar_checker #(.BAR_LOG2(BAR_LOG2), .BAR_IO(BAR_IO)) u_chk (
  .clk(clk), .rst(rst), .cfgValid(cfgValid), .cfgWrite(cfgWrite),
  .cfgRdValid(cfgRdValid), .regionValid(regionValid), .regionBase(regionBase)
);

// File: tb/tb_cfg_header_bar.sv
module tb_cfg_header_bar;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgValid = 1'b0, cfgWrite = 1'b0;
  logic [7:0] cfgOffset = 8'h0;
  logic [2:0] cfgLen = 3'd4;
  logic [31:0] cfgWdata = 32'h0;
  logic [31:0] cfgRdata;
  logic cfgRdValid;
  logic [6:0] regionValid;
  logic [223:0] regionBase;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sbItem_t;
  sbItem_t sbQ[$];

  always #5 clk = ~clk;

  cfg_header_bar dut (
    .clk(clk), .rst(rst), .cfgValid(cfgValid), .cfgWrite(cfgWrite),
    .cfgOffset(cfgOffset), .cfgLen(cfgLen), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .cfgRdValid(cfgRdValid),
    .regionValid(regionValid), .regionBase(regionBase)
  );

  // monitor: pops expected read data
  always @(negedge clk) begin
    if (!rst && cfgRdValid) begin
      sbItem_t it;
      nChecks++;
      if (sbQ.size() == 0) begin
        nFails++;
        $display("FAIL R3 unexpected read data actual=%h expected=none", cfgRdata);
      end else begin
        it = sbQ.pop_front();
        if (cfgRdata !== it.exp) begin
          nFails++;
          $display("FAIL %s actual=%h expected=%h", it.tag, cfgRdata, it.exp);
        end
      end
    end
  end

  task automatic doReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cfgWr(input logic [7:0] off, input logic [2:0] len, input logic [31:0] d);
    @(negedge clk);
    cfgValid = 1'b1; cfgWrite = 1'b1; cfgOffset = off; cfgLen = len; cfgWdata = d;
    @(negedge clk);
    cfgValid = 1'b0; cfgWrite = 1'b0;
  endtask

  task automatic cfgRd(input logic [7:0] off, input logic [2:0] len,
                       input logic [31:0] exp, input string tag);
    sbItem_t it;
    @(negedge clk);
    it.exp = exp; it.tag = tag;
    sbQ.push_back(it);
    cfgValid = 1'b1; cfgWrite = 1'b0; cfgOffset = off; cfgLen = len;
    @(negedge clk);
    cfgValid = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic chkRegion(input int r, input logic v, input logic [31:0] b, input string tag);
    nChecks++;
    if (regionValid[r] !== v || regionBase[32*r +: 32] !== b) begin
      nFails++;
      $display("FAIL %s region %0d actual=%b/%h expected=%b/%h",
               tag, r, regionValid[r], regionBase[32*r +: 32], v, b);
    end
  endtask

  task automatic chkAllOff(input string tag);
    nChecks++;
    if (regionValid !== 7'h0 || regionBase !== '0) begin
      nFails++;
      $display("FAIL %s actual=%b expected=0000000", tag, regionValid);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    cfgRd(8'h00, 3'd4, 32'h5A17C0DE, "R1 identity");
    cfgRd(8'h08, 3'd4, 32'h0B400003, "R1 class/rev");
    cfgRd(8'h04, 3'd2, 32'h0, "R1 command");
    cfgRd(8'h10, 3'd4, 32'h1, "R1 io bar type");
    cfgRd(8'h14, 3'd4, 32'h0, "R1 mem bar type");
    settle();
    chkAllOff("R1 regions off");

    // R2 masked merge
    cfgWr(8'h04, 3'd2, 32'hFFFF);
    cfgRd(8'h04, 3'd2, 32'h0007, "R2 command mask");
    cfgWr(8'h00, 3'd4, 32'hFFFFFFFF);
    cfgRd(8'h00, 3'd4, 32'h5A17C0DE, "R2 identity read-only");
    cfgWr(8'h0C, 3'd1, 32'hA5);
    cfgRd(8'h0C, 3'd1, 32'hA5, "R2 cache line");
    cfgWr(8'h3C, 3'd1, 32'h5B);
    cfgRd(8'h3C, 3'd1, 32'h5B, "R2 interrupt line");
    cfgWr(8'h40, 3'd4, 32'h12345678);
    cfgRd(8'h40, 3'd4, 32'h12345678, "R2 vendor area");

    // R3 lengths and clamping
    cfgWr(8'h80, 3'd1, 32'hFFFFFF11);
    cfgRd(8'h80, 3'd4, 32'h00000011, "R3 single byte write");
    cfgRd(8'h41, 3'd2, 32'h00003456, "R3 two byte read lanes");
    cfgWr(8'hFE, 3'd4, 32'hAABBCCDD);
    cfgRd(8'hFC, 3'd4, 32'hCCDD0000, "R3 write past end dropped");
    cfgRd(8'hFE, 3'd4, 32'h0000CCDD, "R3 read past end zero");

    // R4 size-aligned registers, R5 absent ones
    cfgWr(8'h10, 3'd4, 32'hFFFFFFFF);
    cfgRd(8'h10, 3'd4, 32'hFFFFFFF1, "R4 io bar mask");
    cfgWr(8'h14, 3'd4, 32'hFFFFFFFF);
    cfgRd(8'h14, 3'd4, 32'hFFFFF000, "R4 mem bar mask");
    cfgWr(8'h1C, 3'd4, 32'hFFFFFFFF);
    cfgRd(8'h1C, 3'd4, 32'hFFF00000, "R4 large mem bar mask");
    cfgWr(8'h30, 3'd4, 32'hFFFFFFFF);
    cfgRd(8'h30, 3'd4, 32'hFFFFF801, "R4 rom mask keeps enable");
    cfgWr(8'h18, 3'd4, 32'hFFFFFFFF);
    cfgRd(8'h18, 3'd4, 32'h0, "R5 absent bar reads zero");
    cfgWr(8'h20, 3'd4, 32'hFFFFFFFF);
    cfgRd(8'h20, 3'd4, 32'h0, "R5 absent bar 4 reads zero");
    settle();
    chkAllOff("R7 top-end windows unmapped");

    // R6 io mapping
    cfgWr(8'h10, 3'd4, 32'h00001000); settle();
    chkRegion(0, 1'b1, 32'h1000, "R6 io mapped");
    cfgWr(8'h04, 3'd1, 32'h06); settle();
    chkRegion(0, 1'b0, 32'h0, "R6 io enable off");
    cfgWr(8'h04, 3'd1, 32'h07); settle();
    chkRegion(0, 1'b1, 32'h1000, "R6 io enable on");
    cfgWr(8'h10, 3'd4, 32'h0000FFF0); settle();
    chkRegion(0, 1'b1, 32'hFFF0, "R6 io top of range");
    cfgWr(8'h10, 3'd4, 32'h00010000); settle();
    chkRegion(0, 1'b0, 32'h0, "R6 io beyond 64K R10");
    cfgWr(8'h10, 3'd4, 32'h00001000);

    // R7 memory mapping
    cfgWr(8'h14, 3'd4, 32'h80000000); settle();
    chkRegion(1, 1'b1, 32'h80000000, "R7 mem mapped");
    cfgWr(8'h14, 3'd4, 32'h0); settle();
    chkRegion(1, 1'b0, 32'h0, "R7 mem base zero");
    cfgWr(8'h14, 3'd4, 32'h00002000);
    cfgWr(8'h1C, 3'd4, 32'h12300000); settle();
    chkRegion(1, 1'b1, 32'h2000, "R7 mem small");
    chkRegion(3, 1'b1, 32'h12300000, "R7 mem large");
    chkRegion(2, 1'b0, 32'h0, "R5 absent never maps");
    cfgWr(8'h04, 3'd1, 32'h05); settle();
    chkRegion(1, 1'b0, 32'h0, "R7 mem enable off");
    chkRegion(0, 1'b1, 32'h1000, "R6 io kept when mem off");
    cfgWr(8'h04, 3'd1, 32'h07); settle();
    chkRegion(1, 1'b1, 32'h2000, "R7 mem enable on");

    // R8 / R9 ROM and remap trigger
    cfgWr(8'h30, 3'd4, 32'h00100000); settle();
    chkRegion(6, 1'b0, 32'h0, "R8 rom disabled");
    cfgWr(8'h30, 3'd4, 32'h00100001); settle();
    chkRegion(6, 1'b0, 32'h0, "R9 rom write alone no refresh");
    cfgWr(8'h14, 3'd4, 32'h00003000); settle();
    chkRegion(6, 1'b1, 32'h00100000, "R8 rom mapped after refresh");
    chkRegion(1, 1'b1, 32'h3000, "R9 bar refresh");
    cfgWr(8'h30, 3'd4, 32'h00100000); settle();
    chkRegion(6, 1'b1, 32'h00100000, "R9 rom disable alone held");
    cfgWr(8'h04, 3'd1, 32'h03); settle();
    chkRegion(6, 1'b1, 32'h00100000, "R9 master bit change no refresh");
    cfgWr(8'h14, 3'd4, 32'h00002000); settle();
    chkRegion(6, 1'b0, 32'h0, "R8 rom unmapped after refresh");

    // R11 reset after use
    doReset();
    cfgRd(8'h04, 3'd2, 32'h0, "R11 command cleared");
    cfgRd(8'h0C, 3'd1, 32'h0, "R11 cache line cleared");
    cfgRd(8'h3C, 3'd1, 32'h0, "R11 interrupt line cleared");
    cfgRd(8'h10, 3'd4, 32'h1, "R11 io bar type only");
    cfgRd(8'h14, 3'd4, 32'h0, "R11 mem bar cleared");
    cfgRd(8'h30, 3'd4, 32'h0, "R11 rom cleared");
    cfgRd(8'h00, 3'd4, 32'h5A17C0DE, "R11 identity kept");
    settle();
    chkAllOff("R11 regions off");

    settle();
    nChecks++;
    if (sbQ.size() != 0) begin
      nFails++;
      $display("FAIL R3 missing read data actual=%0d expected=0", sbQ.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule